// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the run-time registers for a bank of general-purpose pins. The pins are grouped into byte-wide ports. Software reaches the registers through a byte-wide register interface with a 4-bit offset. Every port has an output-data register and an input-data register. The first two ports also have an event-enable register and an event-status register.

How each pin drives is set by a per-pin configuration that a separate configuration block supplies:
- An output-enable bit lets the pin drive at all.
- A push-pull bit picks between push-pull and open-drain drive.

Pin inputs pass through a synchronizer before software or the event logic can see them. When an enabled input shows a rising edge, a sticky status bit is set and a single event line is raised.

A 29-pin default gives four ports, and the last port has only five pins. Software changes a single pin by reading the output-data register, changing one bit and writing the byte back.

Top module: `gpio_port_regs`

## Requirements
- R1: Register offsets are as follows. Output data for ports 0, 1, 2 and 3 is at 0x0, 0x4, 0x8 and 0xA. Input data for those ports is at 0x1, 0x5, 0x9 and 0xB. Event enable for ports 0 and 1 is at 0x2 and 0x6. Event status for ports 0 and 1 is at 0x3 and 0x7. Pin n is bit n%8 of port n/8.
- R2: A write with `we_i` high stores `wdata_i` in the addressed output-data register on that clock edge. A read of that offset returns the stored value until the next write to it.
- R3: A pin input level applied before clock edge k appears at bit n%8 of the pin's input-data register after edge k+1. This is the latency of two synchronizer flops.
- R4: `pin_oe_o[n]` is 0 whenever `cfg_oe_i[n]` is 0, whatever the output data.
- R5: When `cfg_oe_i[n]=1` and `cfg_pp_i[n]=1` (push-pull), `pin_oe_o[n]=1` and `pin_out_o[n]` equals the output-data bit.
- R6: When `cfg_oe_i[n]=1` and `cfg_pp_i[n]=0` (open-drain), `pin_oe_o[n]` is 1 only while the output-data bit is 0, and `pin_out_o[n]` is never 1.
- R7: Event-enable registers store the written byte and read it back.
- R8: An event-status bit sets when its synchronized input shows a rising edge while its enable bit is set. The bit can be read one cycle after the new level first shows in the input-data register.
- R9: Writing 1 to an event-status bit clears it. Writing 0 leaves it unchanged. A rising edge in the same cycle as the clear takes priority, and the bit stays set.
- R10: `event_o` is high exactly when some event-status bit and its enable bit are both 1.
- R11: Offsets 0xC to 0xF read 0 and ignore writes. Writes to input-data offsets have no effect.
- R12: Bits 7:5 of port 3 (pins 29 to 31) do not exist. They read 0 in every register and ignore writes.
- R13: After reset, every register reads 0, `pin_oe_o` is all 0 and `event_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register offset |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_in_i | input | 29 | Asynchronous pin input levels |
| cfg_oe_i | input | 29 | Per-pin output enable from the configuration block |
| cfg_pp_i | input | 29 | Per-pin push-pull (1) or open-drain (0) select |
| pin_out_o | output | 29 | Pin drive value |
| pin_oe_o | output | 29 | Pin drive enable |
| event_o | output | 1 | High when any enabled event-status bit is set |

## Verification
The bench goes after the following corner cases:
- **Irregular register map.** A decoder that treated ports 2 and 3 like ports 0 and 1 would move the port 3 registers and return data at 0xC to 0xF.
- **Missing upper bits of port 3.** A design that stored them would read 0xFF where 0x1F is expected.
- **Synchronizer and edge timing.** The bench samples input data and status exactly at the two-cycle and three-cycle points. An extra flop or a missing flop then shows as a miscompare.
- **Open-drain drive.** A design that drives high in open-drain mode would assert the enable while the data bit is 1.
- **Set versus clear in one cycle.** Long random traffic brings a rising edge and a write-1 clear into the same cycle. A design that let the clear win would drop that event.

// File: rtl/gpio_regs_pkg.sv
`timescale 1ns/1ps
package gpio_regs_pkg;

  localparam int unsigned OFF_W = 4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_DOUT,
    REG_DIN,
    REG_EVEN,
    REG_EVST
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] port;
  } reg_sel_t;

  // Ports with events take four offsets each; the rest take two.
  function automatic reg_sel_t decode_offset(input logic [OFF_W-1:0] off,
                                             input int unsigned n_ports,
                                             input int unsigned n_evt);
    reg_sel_t    s;
    int unsigned o;
    int unsigned rel;
    s.kind = REG_NONE;
    s.port = '0;
    o = {28'd0, off};
    if (o < 4 * n_evt) begin
      s.port = 4'(o / 4);
      case (o % 4)
        0:       s.kind = REG_DOUT;
        1:       s.kind = REG_DIN;
        2:       s.kind = REG_EVEN;
        default: s.kind = REG_EVST;
      endcase
    end else begin
      rel = o - 4 * n_evt;
      if (n_evt + rel / 2 < n_ports) begin
        s.port = 4'(n_evt + rel / 2);
        s.kind = (rel % 2 == 0) ? REG_DOUT : REG_DIN;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 29,
  parameter int unsigned EDGE_W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  sync_o,
  output logic [EDGE_W-1:0] rise_o
);

  logic [WIDTH-1:0]  stg_q [STAGES];
  logic [EDGE_W-1:0] prev_q;

  // R3: STAGES flops between pin and input-data register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1][EDGE_W-1:0];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1][EDGE_W-1:0] & ~prev_q;

  a_r8_rise_is_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));

endmodule

// File: rtl/gpio_event_bank.sv
`timescale 1ns/1ps
module gpio_event_bank #(
  parameter int unsigned NUM_EVT_PORTS = 2,
  parameter int unsigned PORT_W        = 8,
  localparam int unsigned EW           = NUM_EVT_PORTS * PORT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_EVT_PORTS-1:0] en_wr_i,
  input  logic [NUM_EVT_PORTS-1:0] st_wr_i,
  input  logic [PORT_W-1:0]        wdata_i,
  input  logic [EW-1:0]            rise_i,
  output logic [EW-1:0]            en_o,
  output logic [EW-1:0]            st_o,
  output logic                     event_o
);

  logic [EW-1:0] en_q, st_q, clr;

  for (genvar p = 0; p < int'(NUM_EVT_PORTS); p++) begin : g_port
    assign clr[p*PORT_W +: PORT_W] = st_wr_i[p] ? wdata_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[p*PORT_W +: PORT_W] <= '0;
      end else if (en_wr_i[p]) begin
        en_q[p*PORT_W +: PORT_W] <= wdata_i;
      end
    end
  end

  // Set has priority over a write-1 clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr) | (rise_i & en_q);
  end

  assign en_o    = en_q;
  assign st_o    = st_q;
  assign event_o = |(st_q & en_q);

  for (genvar b = 0; b < int'(EW); b++) begin : g_chk
    a_r8_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q[b]) |-> ($past(en_q[b]) && $past(rise_i[b])));
    a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_wr_i[b / PORT_W] && wdata_i[b % PORT_W] && !rise_i[b]) |=> !st_q[b]);
  end

  a_r10_event_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !event_o);

endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
module gpio_pin_drive #(
  parameter int unsigned WIDTH = 29
) (
  input  logic [WIDTH-1:0] dout_i,
  input  logic [WIDTH-1:0] cfg_oe_i,
  input  logic [WIDTH-1:0] cfg_pp_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o
);

  for (genvar n = 0; n < int'(WIDTH); n++) begin : g_pin
    logic drive;
    // open-drain releases the line for a 1
    assign drive        = cfg_oe_i[n] & (cfg_pp_i[n] | ~dout_i[n]);
    assign pin_oe_o[n]  = drive;
    assign pin_out_o[n] = drive & dout_i[n];
  end

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 29,
  parameter int unsigned PORT_W        = 8,
  parameter int unsigned NUM_EVT_PORTS = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OFF_W-1:0]    addr_i,
  input  logic                we_i,
  input  logic [PORT_W-1:0]   wdata_i,
  output logic [PORT_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  input  logic [NUM_PINS-1:0] cfg_oe_i,
  input  logic [NUM_PINS-1:0] cfg_pp_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                event_o
);

  localparam int unsigned NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
  localparam int unsigned PAD_W     = NUM_PORTS * PORT_W;
  localparam int unsigned EVT_W     = NUM_EVT_PORTS * PORT_W;
  localparam logic [PAD_W-1:0] IMPL_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_PINS);

  reg_sel_t                 sel;
  logic [NUM_PORTS-1:0]     dout_wr;
  logic [NUM_EVT_PORTS-1:0] en_wr, st_wr;
  logic [PAD_W-1:0]         dout_q, din_pad;
  logic [NUM_PINS-1:0]      din_sync;
  logic [EVT_W-1:0]         rise, en_vec, st_vec;

  assign sel = decode_offset(addr_i, NUM_PORTS, NUM_EVT_PORTS);

  for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_wr
    assign dout_wr[p] = we_i && sel.kind == REG_DOUT && sel.port == 4'(p);
  end

  for (genvar p = 0; p < int'(NUM_EVT_PORTS); p++) begin : g_ewr
    assign en_wr[p] = we_i && sel.kind == REG_EVEN && sel.port == 4'(p);
    assign st_wr[p] = we_i && sel.kind == REG_EVST && sel.port == 4'(p);
  end

  // Output data: only bits of existing pins hold state (R12).
  for (genvar b = 0; b < int'(PAD_W); b++) begin : g_dout
    if (b < int'(NUM_PINS)) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  dout_q[b] <= 1'b0;
        else if (dout_wr[b / PORT_W]) dout_q[b] <= wdata_i[b % PORT_W];
      end
    end else begin : g_tie
      assign dout_q[b] = 1'b0;
    end
  end

  gpio_in_sync #(
    .WIDTH (NUM_PINS),
    .EDGE_W(EVT_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_in_i),
    .sync_o(din_sync),
    .rise_o(rise)
  );

  assign din_pad = PAD_W'(din_sync);

  gpio_event_bank #(
    .NUM_EVT_PORTS(NUM_EVT_PORTS),
    .PORT_W       (PORT_W)
  ) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_wr_i(en_wr),
    .st_wr_i(st_wr),
    .wdata_i(wdata_i),
    .rise_i (rise),
    .en_o   (en_vec),
    .st_o   (st_vec),
    .event_o(event_o)
  );

  gpio_pin_drive #(
    .WIDTH(NUM_PINS)
  ) u_drv (
    .dout_i   (dout_q[NUM_PINS-1:0]),
    .cfg_oe_i (cfg_oe_i),
    .cfg_pp_i (cfg_pp_i),
    .pin_out_o(pin_out_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      if (sel.port == 4'(p)) begin
        if (sel.kind == REG_DOUT) rdata_o = dout_q[p*PORT_W +: PORT_W];
        if (sel.kind == REG_DIN)  rdata_o = din_pad[p*PORT_W +: PORT_W];
      end
    end
    for (int p = 0; p < int'(NUM_EVT_PORTS); p++) begin
      if (sel.port == 4'(p)) begin
        if (sel.kind == REG_EVEN) rdata_o = en_vec[p*PORT_W +: PORT_W];
        if (sel.kind == REG_EVST) rdata_o = st_vec[p*PORT_W +: PORT_W];
      end
    end
  end

  a_r2_dout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(dout_q));
  a_r4_oe_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~cfg_oe_i) == '0);
  a_r6_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~cfg_pp_i) == '0);
  a_r11_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.kind == REG_NONE) |-> (rdata_o == '0));
  a_r12_pad_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.port == 4'(NUM_PORTS - 1) && sel.kind != REG_NONE) |->
      ((rdata_o & ~IMPL_MASK[PAD_W-1 -: PORT_W]) == '0));

endmodule

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [28:0] pins = '0, cfg_oe = '0, cfg_pp = '0;
  logic [7:0]  rdata;
  logic [28:0] pin_out, pin_oe;
  logic        evt;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference state
  bit [28:0] m_dout, m_s1, m_s2, m_prev;
  bit [15:0] m_en, m_st;

  always #10 clk = ~clk;

  gpio_port_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pins), .cfg_oe_i(cfg_oe), .cfg_pp_i(cfg_pp),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .event_o(evt)
  );

  function automatic int port_of(input int a);
    case (a)
      0, 1: return 0;
      4, 5: return 1;
      8, 9: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int m_read(input int a);
    bit [31:0] d, s;
    d = 32'(m_dout);
    s = 32'(m_s2);
    case (a)
      0, 4, 8, 10: return int'((d >> (8 * port_of(a))) & 32'hFF);
      1, 5, 9, 11: return int'((s >> (8 * port_of(a))) & 32'hFF);
      2: return int'(m_en[7:0]);
      6: return int'(m_en[15:8]);
      3: return int'(m_st[7:0]);
      7: return int'(m_st[15:8]);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 4, 8, 10: return "R2";
      1, 5, 9, 11: return "R3";
      2, 6: return "R7";
      3, 7: return "R8";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_st = '0;
    end else begin
      bit [15:0] rise, clr;
      bit [31:0] d;
      rise = m_s2[15:0] & ~m_prev[15:0];
      clr  = '0;
      if (we) begin
        d = 32'(m_dout);
        case (int'(addr))
          0, 4, 8, 10: begin
            d[8*port_of(int'(addr)) +: 8] = wdata;
            m_dout = d[28:0];
          end
          2: m_en[7:0]  = wdata;
          6: m_en[15:8] = wdata;
          3: clr[7:0]   = wdata;
          7: clr[15:8]  = wdata;
          default: ;
        endcase
      end
      m_st = (m_st & ~clr) | (rise & m_en_prev);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
      m_en_prev = m_en;
    end
  end

  // enable as it stood before the edge, captured for the set term
  bit [15:0] m_en_prev;
  always @(negedge clk) m_en_prev = m_en;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [28:0] eoe;
    eoe = cfg_oe & (cfg_pp | ~m_dout);
    chk(tag_of(int'(addr)), int'(rdata), m_read(int'(addr)));
    chk("R4", int'(pin_oe), int'(eoe));
    chk("R5", int'(pin_out), int'(eoe & m_dout));
    chk("R10", int'(evt), int'(|(m_st & m_en)));
  endtask

  task automatic cyc(input bit w, input int a, input int d);
    @(negedge clk);
    we = w; addr = 4'(a); wdata = 8'(d);
    #2;
    if (rst_n) compare_all();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 0, 0);
    chk("R13 reset dout", int'(rdata), 0);
    chk("R13 reset event", int'(evt), 0);
    chk("R13 reset oe", int'(pin_oe), 0);

    cyc(1, 0, 'hFF); cyc(1, 4, 'hFF); cyc(1, 8, 'hFF); cyc(1, 10, 'hFF);
    cyc(0, 0, 0);  chk("R1 port0 dout", int'(rdata), 'hFF);
    cyc(0, 4, 0);  chk("R1 port1 dout", int'(rdata), 'hFF);
    cyc(0, 8, 0);  chk("R1 port2 dout", int'(rdata), 'hFF);
    cyc(0, 10, 0); chk("R12 port3 dout", int'(rdata), 'h1F);
    cyc(1, 4, 'h5A); cyc(0, 4, 0); chk("R2 readback", int'(rdata), 'h5A);

    cyc(1, 12, 'h55); cyc(0, 12, 0); chk("R11 hole", int'(rdata), 0);
    cyc(1, 1, 'hFF);  cyc(0, 1, 0);  chk("R11 din write", int'(rdata), 0);
    cyc(1, 2, 'hA5);  cyc(0, 2, 0);  chk("R7 enable", int'(rdata), 'hA5);

    // open-drain on pin 0 with data 1: released
    cfg_oe = '1; cfg_pp = 29'h1FFF_FFFE;
    cyc(0, 0, 0); chk("R6 od release", int'(pin_oe[0]), 0);
    cyc(1, 0, 'h00);
    cyc(0, 0, 0); chk("R6 od drive low oe", int'(pin_oe[0]), 1);
    chk("R6 od drive low val", int'(pin_out[0]), 0);
    chk("R5 pp bit1", int'(pin_oe[1]), 1);

    // synchronizer and event timing on pin 3
    cyc(1, 2, 'h08);
    @(negedge clk); pins[3] = 1'b1; we = 0; addr = 4'd1; #2; compare_all();
    chk("R3 not yet", int'(rdata), 0);
    cyc(0, 1, 0); chk("R3 one flop", int'(rdata), 0);
    cyc(0, 1, 0); chk("R3 two flops", int'(rdata), 'h08);
    cyc(0, 3, 0); chk("R8 status set", int'(rdata), 'h08);
    chk("R10 event", int'(evt), 1);
    cyc(1, 3, 'h00); cyc(0, 3, 0); chk("R9 write0 keeps", int'(rdata), 'h08);
    cyc(1, 3, 'h08); cyc(0, 3, 0); chk("R9 cleared", int'(rdata), 0);
    chk("R10 event low", int'(evt), 0);

    for (int i = 0; i < 4000; i++) begin
      if (i % 60 == 0) begin
        cfg_oe = 29'($urandom);
        cfg_pp = 29'($urandom);
      end
      if (i % 3 == 0) pins = pins ^ 29'(1 << ($urandom % 29));
      cyc(($urandom % 2) == 1, int'($urandom % 16), int'($urandom % 256));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule